// File: doc/BRIEF.md
# Byte-Port Network Interface Register Block

This block puts a simple frame-based network link behind a small 32-bit register window. Software finds the device by a 64-bit identifier word, polls a busy flag, and moves payload one byte per register access. To receive, it reads the pending byte count and then reads the data port repeatedly. Each read returns the next byte and lowers the count by one. To transmit, it writes a length and then that many bytes to a second data port. The device then streams the frame out and reports completion.

On the link side there is a byte-wide receive stream in and a transmit stream out. Each has valid, ready and an end-of-frame marker. Frames are held in two internal byte buffers whose depth is a parameter. A status register holds a transmit-done flag and a receive-available flag, both write-one-to-clear. It also holds a software test flag that is raised by writing it and dropped by reading the register or by writing all zeros. The interrupt output is active while any of the three flags is set. While the receive flag is set, the link receive side is held off, so no frame overwrites one that software has not yet acknowledged.

Top module: `bytenet_regif`

## Requirements
- R1: The 32-bit words at offsets 0x00 (low) and 0x04 (high) read as the 64-bit parameter `DEV_ID`. The default is the ASCII text "BYTENET0", with its first character in bits 7:0 and its last character in bits 63:56.
- R2: Bit 0 of offset 0x08 reads 1 while a receive frame is partly accepted (at least one byte taken and no end marker yet) or while a transmit frame is being streamed. It reads 0 otherwise, including after reset.
- R3: On acceptance of a receive byte carrying the end marker, the count at offset 0x0c becomes the frame length. Each read of offset 0x1c while the count is non-zero returns the next frame byte in arrival order and lowers the count by one. A read of 0x1c at count 0 returns 0 and changes nothing.
- R4: `link_rx_ready` is low whenever the receive-available flag (bit 1 of offset 0x14) is set and high otherwise. An offered frame is not accepted while it is low.
- R5: Only bits 7:0 of the data ports carry data. Reads of 0x1c return zero in bits 31:8, and bits 31:8 of writes to 0x20 are ignored.
- R6: Writing N to offset 0x10 and then N bytes to offset 0x20 makes the block stream those N bytes in order on the transmit link. Only the last byte carries `link_tx_last`. The data holds steady while ready is low. After the last handshake, offset 0x10 reads 0 and bit 0 of 0x14 is set.
- R7: Writing a 1 to bit 0 or bit 1 of offset 0x14 clears that flag. Writing 0 leaves it alone.
- R8: Writing a non-zero value with bit 31 set to 0x14 sets the test flag (bit 31). A read of 0x14 returns the flag and then clears it. Writing exactly zero clears it. A non-zero write with bit 31 clear leaves it unchanged.
- R9: `irq` is high exactly when at least one of bits 0, 1 and 31 of offset 0x14 is set.
- R10: Offset 0x18 reads the parameter `INFO_WORD` (default 0). Unmapped or misaligned offsets read 0. Writes to read-only offsets (0x00, 0x04, 0x08, 0x0c, 0x18) have no effect.
- R11: A receive frame longer than `DEPTH` keeps only its first `DEPTH` bytes, and its count is `DEPTH`.
- R12: A transmit length larger than `DEPTH` written to 0x10 is stored as `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Register read strobe; side effects at the clock edge |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte offset within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| irq | output | 1 | Interrupt request |
| link_tx_data | output | 8 | Transmit byte |
| link_tx_valid | output | 1 | Transmit byte valid |
| link_tx_last | output | 1 | Transmit byte ends the frame |
| link_tx_ready | input | 1 | Link accepts the transmit byte |
| link_rx_data | input | 8 | Receive byte |
| link_rx_valid | input | 1 | Receive byte valid |
| link_rx_last | input | 1 | Receive byte ends the frame |
| link_rx_ready | output | 1 | Block accepts a receive byte |

## Verification
The hardest state to reach is a second frame offered on the link while the first is still waiting in the buffer. Receive acceptance must then stall, and the pending count must stay intact until software has drained the buffer and acknowledged it. The bench reaches this state by offering a full end-marked byte right after every received frame and checking that the count has not moved. It also sends frames longer than the buffer depth to hit truncation, and it drains the transmit stream under a random ready pattern so that held bytes are observed.

// File: rtl/bytenet_pkg.sv
package bytenet_pkg;
    localparam int unsigned ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_ID_LO  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_ID_HI  = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_BUSY   = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_RXCNT  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_TXCNT  = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_IRQ    = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_INFO   = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_RXDATA = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_TXDATA = 6'h20;

    localparam int unsigned IRQ_BIT_TX   = 0;
    localparam int unsigned IRQ_BIT_RX   = 1;
    localparam int unsigned IRQ_BIT_TEST = 31;

    typedef struct packed {
        logic test;
        logic rx;
        logic tx;
    } irq_st_t;

    typedef enum logic {
        TX_FILL = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;
endpackage

// File: rtl/bytenet_buf.sv
module bytenet_buf #(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/bytenet_rx.sv
module bytenet_rx #(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    link_data,
    input  logic          link_valid,
    input  logic          link_last,
    output logic          link_ready,
    input  logic          stall,
    input  logic          pop,
    output logic [7:0]    pop_data,
    output logic [LW-1:0] count,
    output logic          frame_done,
    output logic          busy
);
    typedef struct packed {
        logic [LW-1:0] wptr;
        logic          in_frame;
        logic [LW-1:0] cnt;
        logic [AW-1:0] rptr;
    } rx_reg_t;

    rx_reg_t       rx_d, rx_q;
    logic          acc;
    logic          we;
    logic [LW-1:0] nlen;
    logic [7:0]    buf_rdata;

    always_comb begin
        rx_d       = rx_q;
        acc        = link_valid && !stall;
        we         = acc && (rx_q.wptr < LW'(DEPTH));
        nlen       = rx_q.wptr;
        frame_done = 1'b0;
        if (rx_q.wptr < LW'(DEPTH)) begin
            nlen = rx_q.wptr + 1'b1;
        end
        if (pop && (rx_q.cnt != '0)) begin
            rx_d.cnt  = rx_q.cnt - 1'b1;
            rx_d.rptr = rx_q.rptr + 1'b1;
        end
        if (acc) begin
            if (link_last) begin
                rx_d.cnt      = nlen;
                rx_d.rptr     = '0;
                rx_d.wptr     = '0;
                rx_d.in_frame = 1'b0;
                frame_done    = 1'b1;
            end else begin
                rx_d.wptr     = nlen;
                rx_d.in_frame = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    bytenet_buf #(.DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .we    (we),
        .waddr (rx_q.wptr[AW-1:0]),
        .wdata (link_data),
        .raddr (rx_q.rptr),
        .rdata (buf_rdata)
    );

    assign link_ready = !stall;
    assign pop_data   = (rx_q.cnt != '0) ? buf_rdata : 8'h00;
    assign count      = rx_q.cnt;
    assign busy       = rx_q.in_frame;
endmodule

// File: rtl/bytenet_tx.sv
module bytenet_tx
    import bytenet_pkg::*;
#(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          len_wr,
    input  logic [31:0]   len_val,
    input  logic          byte_wr,
    input  logic [7:0]    byte_val,
    output logic [7:0]    link_data,
    output logic          link_valid,
    output logic          link_last,
    input  logic          link_ready,
    output logic [LW-1:0] count,
    output logic          frame_done,
    output logic          busy
);
    typedef struct packed {
        tx_state_e     st;
        logic [LW-1:0] len;
        logic [LW-1:0] wptr;
        logic [LW-1:0] rptr;
    } tx_reg_t;

    tx_reg_t       tx_d, tx_q;
    logic          we;
    logic [LW-1:0] len_cap;

    always_comb begin
        tx_d       = tx_q;
        we         = 1'b0;
        frame_done = 1'b0;
        link_valid = 1'b0;
        link_last  = 1'b0;
        if (len_val > 32'(DEPTH)) begin
            len_cap = LW'(DEPTH);
        end else begin
            len_cap = len_val[LW-1:0];
        end
        case (tx_q.st)
            TX_FILL: begin
                if (len_wr) begin
                    tx_d.len  = len_cap;
                    tx_d.wptr = '0;
                end else if (byte_wr && (tx_q.wptr < tx_q.len)) begin
                    we        = 1'b1;
                    tx_d.wptr = tx_q.wptr + 1'b1;
                    if ((tx_q.wptr + 1'b1) == tx_q.len) begin
                        tx_d.st   = TX_SEND;
                        tx_d.rptr = '0;
                    end
                end
            end
            default: begin
                link_valid = 1'b1;
                link_last  = (tx_q.rptr == (tx_q.len - 1'b1));
                if (link_ready) begin
                    if (link_last) begin
                        tx_d.st    = TX_FILL;
                        tx_d.len   = '0;
                        tx_d.wptr  = '0;
                        tx_d.rptr  = '0;
                        frame_done = 1'b1;
                    end else begin
                        tx_d.rptr = tx_q.rptr + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '{st: TX_FILL, len: '0, wptr: '0, rptr: '0};
        end else begin
            tx_q <= tx_d;
        end
    end

    bytenet_buf #(.DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .we    (we),
        .waddr (tx_q.wptr[AW-1:0]),
        .wdata (byte_val),
        .raddr (tx_q.rptr[AW-1:0]),
        .rdata (link_data)
    );

    assign count = tx_q.len;
    assign busy  = (tx_q.st == TX_SEND);
endmodule

// File: rtl/bytenet_regif.sv
module bytenet_regif
    import bytenet_pkg::*;
#(
    parameter int unsigned DEPTH     = 2048,
    parameter logic [63:0] DEV_ID    = 64'h3054_454E_4554_5942,
    parameter logic [31:0] INFO_WORD = 32'h0000_0000,
    localparam int unsigned LW = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic [7:0]        link_tx_data,
    output logic              link_tx_valid,
    output logic              link_tx_last,
    input  logic              link_tx_ready,
    input  logic [7:0]        link_rx_data,
    input  logic              link_rx_valid,
    input  logic              link_rx_last,
    output logic              link_rx_ready
);
    irq_st_t       st_d, st_q;
    logic [LW-1:0] rx_count, tx_count;
    logic [7:0]    rx_pop_data;
    logic          rx_done, tx_done;
    logic          rx_busy, tx_busy, busy;
    logic          rx_pop, tx_len_wr, tx_byte_wr;

    assign rx_pop     = bus_rd && (bus_addr == OFS_RXDATA);
    assign tx_len_wr  = bus_wr && (bus_addr == OFS_TXCNT);
    assign tx_byte_wr = bus_wr && (bus_addr == OFS_TXDATA);
    assign busy       = rx_busy || tx_busy;

    bytenet_rx #(.DEPTH(DEPTH)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_data  (link_rx_data),
        .link_valid (link_rx_valid),
        .link_last  (link_rx_last),
        .link_ready (link_rx_ready),
        .stall      (st_q.rx),
        .pop        (rx_pop),
        .pop_data   (rx_pop_data),
        .count      (rx_count),
        .frame_done (rx_done),
        .busy       (rx_busy)
    );

    bytenet_tx #(.DEPTH(DEPTH)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .len_wr     (tx_len_wr),
        .len_val    (bus_wdata),
        .byte_wr    (tx_byte_wr),
        .byte_val   (bus_wdata[7:0]),
        .link_data  (link_tx_data),
        .link_valid (link_tx_valid),
        .link_last  (link_tx_last),
        .link_ready (link_tx_ready),
        .count      (tx_count),
        .frame_done (tx_done),
        .busy       (tx_busy)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_ID_LO:  bus_rdata = DEV_ID[31:0];
            OFS_ID_HI:  bus_rdata = DEV_ID[63:32];
            OFS_BUSY:   bus_rdata = {31'b0, busy};
            OFS_RXCNT:  bus_rdata = 32'(rx_count);
            OFS_TXCNT:  bus_rdata = 32'(tx_count);
            OFS_IRQ: begin
                bus_rdata[IRQ_BIT_TEST] = st_q.test;
                bus_rdata[IRQ_BIT_RX]   = st_q.rx;
                bus_rdata[IRQ_BIT_TX]   = st_q.tx;
            end
            OFS_INFO:   bus_rdata = INFO_WORD;
            OFS_RXDATA: bus_rdata = {24'b0, rx_pop_data};
            default:    bus_rdata = '0;
        endcase
    end

    // status next state: read-clear, then software write, then hardware set
    always_comb begin
        st_d = st_q;
        if (bus_rd && (bus_addr == OFS_IRQ)) begin
            st_d.test = 1'b0;
        end
        if (bus_wr && (bus_addr == OFS_IRQ)) begin
            if (bus_wdata == '0) begin
                st_d.test = 1'b0;
            end else begin
                if (bus_wdata[IRQ_BIT_TX]) st_d.tx = 1'b0;
                if (bus_wdata[IRQ_BIT_RX]) st_d.rx = 1'b0;
                if (bus_wdata[IRQ_BIT_TEST]) st_d.test = 1'b1;
            end
        end
        if (tx_done) st_d.tx = 1'b1;
        if (rx_done) st_d.rx = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.tx || st_q.rx || st_q.test;
endmodule

// File: rtl/bytenet_chk.sv
module bytenet_chk
    import bytenet_pkg::*;
#(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned LW = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wbit0,
    input logic              link_tx_valid,
    input logic              link_tx_ready,
    input logic              link_tx_last,
    input logic [7:0]        link_tx_data,
    input logic              link_rx_valid,
    input logic              link_rx_ready,
    input logic              link_rx_last,
    input irq_st_t           st,
    input logic [LW-1:0]     rx_cnt,
    input logic              busy
);
    // R4: receive side held off while the receive flag is set
    a_r4_rx_stall: assert property (@(posedge clk) disable iff (!rst_n)
        st.rx |-> !link_rx_ready);

    // R6: a stalled transmit byte stays put
    a_r6_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (link_tx_valid && !link_tx_ready) |=>
            (link_tx_valid && $stable(link_tx_data) && $stable(link_tx_last)));

    // R2: streaming a frame shows as busy
    a_r2_busy_tx: assert property (@(posedge clk) disable iff (!rst_n)
        link_tx_valid |-> busy);

    // R7: write-one clears transmit-done unless a frame ends in the same cycle
    a_r7_tx_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == OFS_IRQ) && wbit0 &&
         !(link_tx_valid && link_tx_ready && link_tx_last)) |=> !st.tx);

    // R8: reading the status register drops the test flag
    a_r8_test_rdclr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && (bus_addr == OFS_IRQ)) |=> !st.test);

    // R3: each data-port read lowers the pending count by one
    a_r3_rx_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == OFS_RXDATA) && (rx_cnt != '0) &&
         !(link_rx_valid && link_rx_ready && link_rx_last)) |=>
            (rx_cnt == LW'($past(rx_cnt) - 1'b1)));

    // R11: pending count never exceeds the buffer depth
    a_r11_cap: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= LW'(DEPTH));
endmodule

bind bytenet_regif bytenet_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .wbit0         (bus_wdata[0]),
    .link_tx_valid (link_tx_valid),
    .link_tx_ready (link_tx_ready),
    .link_tx_last  (link_tx_last),
    .link_tx_data  (link_tx_data),
    .link_rx_valid (link_rx_valid),
    .link_rx_ready (link_rx_ready),
    .link_rx_last  (link_rx_last),
    .st            (st_q),
    .rx_cnt        (rx_count),
    .busy          (busy)
);

// File: tb/tb_bytenet_regif.sv
module tb_bytenet_regif;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_rd, bus_wr;
    logic [5:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        irq;
    logic [7:0]  link_tx_data;
    logic        link_tx_valid, link_tx_last, link_tx_ready;
    logic [7:0]  link_rx_data;
    logic        link_rx_valid, link_rx_last, link_rx_ready;

    always #10 clk = ~clk;

    bytenet_regif #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .link_tx_data(link_tx_data), .link_tx_valid(link_tx_valid),
        .link_tx_last(link_tx_last), .link_tx_ready(link_tx_ready),
        .link_rx_data(link_rx_data), .link_rx_valid(link_rx_valid),
        .link_rx_last(link_rx_last), .link_rx_ready(link_rx_ready)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [7:0] fr [0:31];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        bus_rd = 1'b1; bus_addr = a;
        #2 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] v);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    function automatic logic [63:0] id_of(input string s);
        logic [63:0] r = '0;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = 8'(s[i]);
        return r;
    endfunction

    function automatic int cap(input int n);
        return (n > DEPTH) ? DEPTH : n;
    endfunction

    task automatic run_rx(input int n);
        logic [31:0] v;
        int m = cap(n);
        for (int i = 0; i < n; i++) fr[i] = 8'($urandom);
        for (int i = 0; i < n; i++) begin
            link_rx_valid = 1'b1; link_rx_data = fr[i]; link_rx_last = (i == n - 1);
            #2;
            while (!link_rx_ready) begin @(negedge clk); #2; end
            @(negedge clk);
            link_rx_valid = 1'b0; link_rx_last = 1'b0;
            if (i == 0 && n > 1) begin
                rd(6'h08, v); chk("R2 busy mid-frame", v, 32'h1);
            end
        end
        rd(6'h0C, v); chk((n > DEPTH) ? "R11 capped count" : "R3 count", v, 32'(m));
        rd(6'h14, v); chk("R3 rx flag", v, 32'h2);
        chk("R9 irq with rx flag", 32'(irq), 32'h1);
        chk("R4 ready low", 32'(link_rx_ready), 32'h0);
        // offer a second frame while held off
        link_rx_valid = 1'b1; link_rx_data = 8'hA5; link_rx_last = 1'b1;
        @(negedge clk);
        link_rx_valid = 1'b0; link_rx_last = 1'b0;
        rd(6'h0C, v); chk("R4 count kept under stall", v, 32'(m));
        for (int i = 0; i < m; i++) begin
            rd(6'h1C, v); chk((n > DEPTH) ? "R11 data" : "R5 R3 data", v, {24'h0, fr[i]});
        end
        rd(6'h0C, v); chk("R3 drained", v, 32'h0);
        rd(6'h1C, v); chk("R3 empty read", v, 32'h0);
        wr(6'h14, 32'h2);
        rd(6'h14, v); chk("R7 rx clear", v, 32'h0);
        chk("R4 ready back", 32'(link_rx_ready), 32'h1);
        chk("R9 irq low", 32'(irq), 32'h0);
    endtask

    task automatic run_tx(input int n);
        logic [31:0] v;
        int m = cap(n);
        int idx = 0;
        int guard = 0;
        wr(6'h10, 32'(n));
        rd(6'h10, v); chk((n > DEPTH) ? "R12 len cap" : "R6 len", v, 32'(m));
        for (int i = 0; i < m; i++) begin
            fr[i] = 8'($urandom);
            wr(6'h20, {24'($urandom), fr[i]});
        end
        #2 chk("R6 valid", 32'(link_tx_valid), 32'h1);
        rd(6'h08, v); chk("R2 busy send", v, 32'h1);
        while (idx < m && guard < 1000) begin
            link_tx_ready = 1'($urandom);
            #2;
            if (link_tx_valid && link_tx_ready) begin
                chk("R5 R6 tx byte", {24'h0, link_tx_data}, {24'h0, fr[idx]});
                chk("R6 last", 32'(link_tx_last), 32'(idx == m - 1));
                idx++;
            end
            @(negedge clk);
            guard++;
        end
        link_tx_ready = 1'b0;
        #2 chk("R6 idle", 32'(link_tx_valid), 32'h0);
        @(negedge clk);
        rd(6'h10, v); chk("R6 len cleared", v, 32'h0);
        rd(6'h14, v); chk("R6 done flag", v, 32'h1);
        chk("R9 irq tx", 32'(irq), 32'h1);
        wr(6'h14, 32'h0000_0002);
        rd(6'h14, v); chk("R7 other bit untouched", v, 32'h1);
        wr(6'h14, 32'h1);
        rd(6'h14, v); chk("R7 tx clear", v, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [63:0] id;
        void'($urandom(32'd2024));
        rst_n = 1'b0; bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
        link_tx_ready = 0; link_rx_valid = 0; link_rx_last = 0; link_rx_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rd(6'h08, v); chk("R2 reset busy", v, 32'h0);
        rd(6'h0C, v); chk("R3 reset rx count", v, 32'h0);
        rd(6'h10, v); chk("R6 reset tx count", v, 32'h0);
        rd(6'h14, v); chk("R7 reset flags", v, 32'h0);
        chk("R9 reset irq", 32'(irq), 32'h0);
        chk("R4 reset ready", 32'(link_rx_ready), 32'h1);
        chk("R6 reset valid", 32'(link_tx_valid), 32'h0);

        id = id_of("BYTENET0");
        rd(6'h00, v); chk("R1 id low", v, id[31:0]);
        rd(6'h04, v); chk("R1 id high", v, id[63:32]);

        rd(6'h18, v); chk("R10 info", v, 32'h0);
        rd(6'h24, v); chk("R10 unmapped", v, 32'h0);
        rd(6'h3C, v); chk("R10 unmapped top", v, 32'h0);
        rd(6'h01, v); chk("R10 misaligned", v, 32'h0);
        wr(6'h00, 32'hFFFF_FFFF);
        rd(6'h00, v); chk("R10 id write ignored", v, id[31:0]);
        wr(6'h0C, 32'h5);
        rd(6'h0C, v); chk("R10 rx count write ignored", v, 32'h0);
        wr(6'h08, 32'h1);
        rd(6'h08, v); chk("R10 busy write ignored", v, 32'h0);

        wr(6'h14, 32'h8000_0000);
        chk("R9 irq test", 32'(irq), 32'h1);
        wr(6'h14, 32'h1);
        rd(6'h14, v); chk("R8 test set", v, 32'h8000_0000);
        rd(6'h14, v); chk("R8 read clears", v, 32'h0);
        chk("R9 irq after read", 32'(irq), 32'h0);
        wr(6'h14, 32'h8000_0000);
        wr(6'h14, 32'h0);
        chk("R8 zero write clears", 32'(irq), 32'h0);
        rd(6'h14, v); chk("R8 zero write value", v, 32'h0);

        run_rx(1);
        run_rx(DEPTH);
        run_rx(DEPTH + 4);
        for (int k = 0; k < 6; k++) run_rx(1 + int'($urandom % DEPTH));

        run_tx(1);
        run_tx(DEPTH);
        run_tx(100);
        for (int k = 0; k < 5; k++) run_tx(1 + int'($urandom % DEPTH));

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule